// File: doc/BRIEF.md
# Posted Register-Write Front End with Per-Register Pending Tracking

This block sits between a timer's bus-clock register interface and its functional-clock register file. The bus writes a register as a single-cycle strobe with an address and data. Some registers are write-sensitive and must be carried across into the functional clock domain. Each of these has its own transfer channel and its own pending flag. The flag rises on the accepted write and falls only after the functional side has applied the value and its acknowledge has come back to the bus side. Every other register is forwarded at once on a bus-side direct write port.

In posted mode, which is the mode after reset, the bus never waits. Software polls the pending flags, and a write to a register whose flag is still set is dropped. With posted mode turned off, the bus ready is pulled low after a tracked write and stays low until that transfer has completed. In this mode the pending flags read as zero.

The interface control register also starts a soft reset. The soft reset first lets any transfers already in flight finish. It then sends a one-shot clear into the functional domain and reports completion on a reset-done status bit.

Top module: `wp_posted_front`

## Requirements
- R1: In posted mode, an accepted write to a tracked offset sets that offset's pending bit from the next bus cycle. The map is 0x24→bit 0, 0x28→1, 0x2C→2, 0x30→3, 0x38→4, 0x48→5, 0x4C→6, 0x50→7, 0x54→8, 0x58→9. No pending bit is set without such a write.
- R2: Each accepted tracked write to bit i produces exactly one pulse on `f_we[i]`, with its data on `f_wdata[i*DW +: DW]`. The pending bit then clears within a bounded number of bus cycles.
- R3: A write to a tracked register whose pending bit is still set is dropped. Only the first value reaches the functional side.
- R4: Tracked registers transfer independently, so several pending bits can be set at the same time.
- R5: A write to any offset that is not tracked, other than 0x34 and 0x40, appears on `dir_we`/`dir_addr`/`dir_data` one bus cycle later and sets no pending bit.
- R6: A write to offset 0x34 (the pending status) has no effect: no direct write and no pending bit.
- R7: Bit 2 of a write to offset 0x40 sets posted mode. Posted mode is 1 after reset and is visible on `posted_o`.
- R8: With posted mode off, the cycle after an accepted tracked write drives `b_ready` low until the transfer completes. Writes presented while `b_ready` is low are ignored, and `pend_stat` reads zero. With posted mode on, `b_ready` stays high.
- R9: A write to 0x40 with bit 1 set starts a soft reset. `reset_done` falls on the next bus cycle. `f_clear` pulses exactly once and zeroes the functional data outputs, and then `reset_done` returns high. The request clears itself.
- R10: The soft reset waits for in-flight transfers to complete. Tracked writes made while `reset_done` is low are dropped.
- R11: After reset, `pend_stat` is 0, `b_ready`, `reset_done` and `posted_o` are 1, and there are no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst | input | 1 | Synchronous active-high reset, bus domain |
| b_wr | input | 1 | Write strobe, taken when `b_ready` is high |
| b_addr | input | 8 | Register byte offset |
| b_wdata | input | DW | Write data |
| b_ready | output | 1 | Low while a non-posted write is stalled |
| pend_stat | output | 10 | Pending status, one bit per tracked register |
| posted_o | output | 1 | Current posted mode |
| reset_done | output | 1 | 1 when no soft reset is in progress |
| dir_we | output | 1 | Direct register write strobe |
| dir_addr | output | 8 | Direct write offset |
| dir_data | output | DW | Direct write data |
| fclk | input | 1 | Functional clock |
| frst | input | 1 | Synchronous active-high reset, functional domain |
| f_we | output | 10 | Functional-domain write strobe per tracked register |
| f_wdata | output | 10*DW | Functional-domain data, one slice per tracked register |
| f_clear | output | 1 | One-cycle functional-domain clear from soft reset |

## Verification
The bench sends a second write to the control register while the first is still in flight. A design that queued or overwrote the value instead of dropping it would deliver two strobes or the wrong final value. It starts a soft reset while a transfer is pending and then writes during the reset. If the design cleared before draining, or accepted writes during the reset, the bench would see extra strobes or non-zero data after the clear. It also turns posted mode off. In that mode a missing stall, or pending bits that leak through the mask, would show up on every cycle the reference model compares. Writes to the read-only status offset and to direct registers check that the decoder keeps the three classes of offset apart.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int NTRK = 10;
  localparam logic [7:0] OFF_PSTAT = 8'h34;
  localparam logic [7:0] OFF_IFCTL = 8'h40;
  localparam int IFCTL_SRST = 1;
  localparam int IFCTL_POST = 2;

  // one-hot select of the tracked register for a byte offset
  function automatic logic [NTRK-1:0] trk_sel(input logic [7:0] a);
    logic [NTRK-1:0] s;
    s = '0;
    case (a)
      8'h24: s[0] = 1'b1;
      8'h28: s[1] = 1'b1;
      8'h2C: s[2] = 1'b1;
      8'h30: s[3] = 1'b1;
      8'h38: s[4] = 1'b1;
      8'h48: s[5] = 1'b1;
      8'h4C: s[6] = 1'b1;
      8'h50: s[7] = 1'b1;
      8'h54: s[8] = 1'b1;
      8'h58: s[9] = 1'b1;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/wp_sync.sv
module wp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/wp_chan.sv
// One tracked register: four-phase req/ack across the clock boundary.
// The held data stays stable from req rise until the ack returns.
module wp_chan #(
  parameter int DW   = 32,
  parameter int SYNC = 2
) (
  input  logic          bclk,
  input  logic          brst,
  input  logic          start,
  input  logic [DW-1:0] din,
  output logic          busy,
  input  logic          fclk,
  input  logic          frst,
  input  logic          f_clr,
  output logic          f_we,
  output logic [DW-1:0] f_data
);
  logic          req;
  logic          ack;
  logic          ack_b;
  logic          req_f;
  logic [DW-1:0] hold;

  wp_sync #(.STAGES(SYNC)) u_req_sync (.clk(fclk), .rst(frst), .d(req), .q(req_f));
  wp_sync #(.STAGES(SYNC)) u_ack_sync (.clk(bclk), .rst(brst), .d(ack), .q(ack_b));

  always_ff @(posedge bclk) begin
    if (brst) begin
      req  <= 1'b0;
      hold <= '0;
    end else if (start) begin
      req  <= 1'b1;
      hold <= din;
    end else if (ack_b) begin
      req  <= 1'b0;
    end
  end

  assign busy = req | ack_b;

  always_ff @(posedge fclk) begin
    if (frst) begin
      ack    <= 1'b0;
      f_we   <= 1'b0;
      f_data <= '0;
    end else begin
      ack  <= req_f;
      f_we <= req_f & ~ack;
      if (f_clr)              f_data <= '0;
      else if (req_f && !ack) f_data <= hold;
    end
  end
endmodule

// File: rtl/wp_posted_front.sv
module wp_posted_front #(
  parameter int DW   = 32,
  parameter int SYNC = 2
) (
  input  logic                      bclk,
  input  logic                      brst,
  input  logic                      b_wr,
  input  logic [7:0]                b_addr,
  input  logic [DW-1:0]             b_wdata,
  output logic                      b_ready,
  output logic [wp_pkg::NTRK-1:0]   pend_stat,
  output logic                      posted_o,
  output logic                      reset_done,
  output logic                      dir_we,
  output logic [7:0]                dir_addr,
  output logic [DW-1:0]             dir_data,
  input  logic                      fclk,
  input  logic                      frst,
  output logic [wp_pkg::NTRK-1:0]   f_we,
  output logic [wp_pkg::NTRK*DW-1:0] f_wdata,
  output logic                      f_clear
);
  import wp_pkg::*;
  localparam int NT = NTRK;

  logic [NT-1:0] sel;
  logic [NT-1:0] busy;
  logic [NT-1:0] start;
  logic          is_trk;
  logic          wr_ok;
  logic          posted;
  logic          stall;
  logic          rst_pend;
  logic          sreq;
  logic          sack;
  logic          sack_b;
  logic          sreq_f;

  assign sel    = trk_sel(b_addr);
  assign is_trk = |sel;
  assign wr_ok  = b_wr && !stall;
  assign start  = (wr_ok && reset_done) ? (sel & ~busy) : '0;

  genvar g;
  generate
    for (g = 0; g < NT; g++) begin : g_chan
      wp_chan #(.DW(DW), .SYNC(SYNC)) u_chan (
        .bclk  (bclk),
        .brst  (brst),
        .start (start[g]),
        .din   (b_wdata),
        .busy  (busy[g]),
        .fclk  (fclk),
        .frst  (frst),
        .f_clr (f_clear),
        .f_we  (f_we[g]),
        .f_data(f_wdata[g*DW +: DW])
      );
    end
  endgenerate

  always_ff @(posedge bclk) begin
    if (brst) begin
      posted   <= 1'b1;
      stall    <= 1'b0;
      rst_pend <= 1'b0;
      sreq     <= 1'b0;
      dir_we   <= 1'b0;
      dir_addr <= '0;
      dir_data <= '0;
    end else begin
      dir_we <= wr_ok && !is_trk && b_addr != OFF_PSTAT && b_addr != OFF_IFCTL;
      if (wr_ok && !is_trk && b_addr != OFF_PSTAT && b_addr != OFF_IFCTL) begin
        dir_addr <= b_addr;
        dir_data <= b_wdata;
      end
      if (wr_ok && b_addr == OFF_IFCTL) begin
        posted <= b_wdata[IFCTL_POST];
        if (b_wdata[IFCTL_SRST] && reset_done) rst_pend <= 1'b1;
      end
      if ((|start) && !posted)     stall <= 1'b1;
      else if (stall && busy == '0) stall <= 1'b0;
      if (rst_pend && busy == '0 && !sreq) begin
        sreq     <= 1'b1;
        rst_pend <= 1'b0;
      end else if (sack_b) begin
        sreq     <= 1'b0;
      end
    end
  end

  wp_sync #(.STAGES(SYNC)) u_sreq_sync (.clk(fclk), .rst(frst), .d(sreq), .q(sreq_f));
  wp_sync #(.STAGES(SYNC)) u_sack_sync (.clk(bclk), .rst(brst), .d(sack), .q(sack_b));

  always_ff @(posedge fclk) begin
    if (frst) begin
      sack    <= 1'b0;
      f_clear <= 1'b0;
    end else begin
      sack    <= sreq_f;
      f_clear <= sreq_f & ~sack;
    end
  end

  assign reset_done = !(rst_pend || sreq || sack_b);
  assign b_ready    = !stall;
  assign posted_o   = posted;
  assign pend_stat  = posted ? busy : '0;
endmodule

// File: rtl/wp_posted_front_chk.sv
module wp_posted_front_chk #(
  parameter int DW = 32
) (
  input logic                    bclk,
  input logic                    brst,
  input logic                    fclk,
  input logic                    frst,
  input logic                    b_wr,
  input logic [7:0]              b_addr,
  input logic [DW-1:0]           b_wdata,
  input logic                    b_ready,
  input logic [wp_pkg::NTRK-1:0] pend_stat,
  input logic [wp_pkg::NTRK-1:0] busy,
  input logic                    posted_o,
  input logic                    reset_done,
  input logic                    dir_we,
  input logic [DW-1:0]           dir_data,
  input logic                    f_clear
);
  import wp_pkg::*;

  p_set_ctl_r1: assert property (@(posedge bclk) disable iff (brst)
    (b_wr && b_ready && reset_done && posted_o && b_addr == 8'h24 && !busy[0]) |=> pend_stat[0]);

  p_direct_r5: assert property (@(posedge bclk) disable iff (brst)
    (b_wr && b_ready && b_addr == 8'h1C) |=> (dir_we && dir_data == $past(b_wdata)));

  p_ro_stat_r6: assert property (@(posedge bclk) disable iff (brst)
    (b_wr && b_addr == OFF_PSTAT) |=> (!dir_we && (pend_stat & ~$past(pend_stat)) == '0));

  p_stall_r8: assert property (@(posedge bclk) disable iff (brst)
    (b_wr && b_ready && reset_done && !posted_o && ((trk_sel(b_addr) & ~busy) != '0)) |=> !b_ready);

  p_posted_ready_r8: assert property (@(posedge bclk) disable iff (brst)
    posted_o |-> b_ready);

  p_srst_start_r9: assert property (@(posedge bclk) disable iff (brst)
    (b_wr && b_ready && b_addr == OFF_IFCTL && b_wdata[IFCTL_SRST] && reset_done) |=> !reset_done);

  p_clear_pulse_r9: assert property (@(posedge fclk) disable iff (frst)
    f_clear |=> !f_clear);

  p_no_new_pend_r10: assert property (@(posedge bclk) disable iff (brst)
    (!reset_done && !b_wr) |=> ((pend_stat & ~$past(pend_stat)) == '0));
endmodule

bind wp_posted_front wp_posted_front_chk #(.DW(DW)) u_wp_chk (
  .bclk      (bclk),
  .brst      (brst),
  .fclk      (fclk),
  .frst      (frst),
  .b_wr      (b_wr),
  .b_addr    (b_addr),
  .b_wdata   (b_wdata),
  .b_ready   (b_ready),
  .pend_stat (pend_stat),
  .busy      (busy),
  .posted_o  (posted_o),
  .reset_done(reset_done),
  .dir_we    (dir_we),
  .dir_data  (dir_data),
  .f_clear   (f_clear)
);

// File: tb/test_wp_posted_front.sv
`timescale 1ns/1ps
module test_wp_posted_front;
  localparam int DW   = 32;
  localparam int NT   = 10;
  localparam int MINW = 3;
  localparam int MAXW = 40;

  logic bclk = 1'b0, fclk = 1'b0;
  logic brst = 1'b1, frst = 1'b1;
  logic b_wr = 1'b0;
  logic [7:0] b_addr = '0;
  logic [DW-1:0] b_wdata = '0;
  logic b_ready, posted_o, reset_done, dir_we, f_clear;
  logic [NT-1:0] pend_stat, f_we;
  logic [7:0] dir_addr;
  logic [DW-1:0] dir_data;
  logic [NT*DW-1:0] f_wdata;

  always #2 bclk = ~bclk;
  always #3 fclk = ~fclk;

  wp_posted_front #(.DW(DW), .SYNC(2)) i_wp_posted_front (
    .bclk(bclk), .brst(brst), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_ready(b_ready), .pend_stat(pend_stat), .posted_o(posted_o),
    .reset_done(reset_done), .dir_we(dir_we), .dir_addr(dir_addr),
    .dir_data(dir_data), .fclk(fclk), .frst(frst), .f_we(f_we),
    .f_wdata(f_wdata), .f_clear(f_clear));

  int total = 0, bad = 0;
  bit fin = 0;

  int age [NT];
  int exp_cnt [NT], got_cnt [NT];
  logic [DW-1:0] exp_last [NT], got_last [NT];
  bit m_posted = 1;
  int m_stall = -1, m_rst = -1, clr_cnt = 0;
  bit m_dir = 0;
  logic [7:0] m_dir_a = '0;
  logic [DW-1:0] m_dir_d = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int map_idx(input logic [7:0] a);
    case (a)
      8'h24: return 0; 8'h28: return 1; 8'h2C: return 2; 8'h30: return 3;
      8'h38: return 4; 8'h48: return 5; 8'h4C: return 6; 8'h50: return 7;
      8'h54: return 8; 8'h58: return 9;
      default: return -1;
    endcase
  endfunction

  initial for (int i = 0; i < NT; i++) begin
    age[i] = -1; exp_cnt[i] = 0; got_cnt[i] = 0; exp_last[i] = '0; got_last[i] = '0;
  end

  // behavioural reference: advances on each bus edge from the driven inputs
  always @(posedge bclk) if (!brst) begin
    for (int i = 0; i < NT; i++) if (age[i] >= 0) age[i]++;
    if (m_stall >= 0) m_stall++;
    if (m_rst >= 0) m_rst++;
    m_dir = 0;
    if (b_wr && m_stall < 0) begin
      if (map_idx(b_addr) >= 0) begin
        if (m_rst < 0 && age[map_idx(b_addr)] < 0) begin
          age[map_idx(b_addr)] = 0;
          exp_cnt[map_idx(b_addr)]++;
          exp_last[map_idx(b_addr)] = b_wdata;
          if (!m_posted) m_stall = 0;
        end
      end else if (b_addr == 8'h40) begin
        m_posted = b_wdata[2];
        if (b_wdata[1] && m_rst < 0) m_rst = 0;
      end else if (b_addr != 8'h34) begin
        m_dir = 1; m_dir_a = b_addr; m_dir_d = b_wdata;
      end
    end
  end

  // every-cycle comparison against the reference
  always @(negedge bclk) if (!brst) begin
    chk(posted_o == m_posted, "R7", "posted_o", DW'(posted_o), DW'(m_posted));
    for (int i = 0; i < NT; i++) begin
      if (!m_posted) begin
        if (pend_stat[i]) chk(0, "R8", "pend bit visible in non-posted", DW'(i), 0);
        if (age[i] > MAXW) age[i] = -1;
      end else if (age[i] >= 0 && age[i] <= MINW) begin
        if (!pend_stat[i]) chk(0, "R1", "pend bit not set", DW'(i), 1);
      end else if (age[i] < 0) begin
        if (pend_stat[i]) chk(0, "R1", "spurious pend bit", DW'(i), 0);
      end else if (!pend_stat[i]) begin
        age[i] = -1;
      end else if (age[i] > MAXW) begin
        chk(0, "R2", "pend bit never cleared", DW'(i), 0);
        age[i] = -1;
      end
    end
    if (m_stall >= 0) begin
      if (m_stall <= MINW && b_ready) chk(0, "R8", "ready high during stall", 1, 0);
      else if (b_ready) begin
        m_stall = -1;
        for (int i = 0; i < NT; i++) age[i] = -1;
      end else if (m_stall > MAXW) begin
        chk(0, "R8", "stall never released", 0, 1);
        m_stall = -1;
      end
    end else begin
      chk(b_ready, "R8", "b_ready", DW'(b_ready), 1);
    end
    if (m_rst >= 0) begin
      if (m_rst <= MINW && reset_done) chk(0, "R9", "reset_done high early", 1, 0);
      else if (reset_done) m_rst = -1;
      else if (m_rst > 2*MAXW) begin
        chk(0, "R9", "soft reset never done", 0, 1);
        m_rst = -1;
      end
    end else begin
      chk(reset_done, "R9", "reset_done", DW'(reset_done), 1);
    end
    chk(dir_we == m_dir, "R5", "dir_we", DW'(dir_we), DW'(m_dir));
    if (m_dir) begin
      chk(dir_addr == m_dir_a, "R5", "dir_addr", DW'(dir_addr), DW'(m_dir_a));
      chk(dir_data == m_dir_d, "R5", "dir_data", dir_data, m_dir_d);
    end
  end

  always @(negedge fclk) if (!frst) begin
    for (int i = 0; i < NT; i++) if (f_we[i]) begin
      got_cnt[i]++;
      got_last[i] = f_wdata[i*DW +: DW];
    end
    if (f_clear) clr_cnt++;
  end

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge bclk);
    b_wr = 1'b1; b_addr = a; b_wdata = d;
    @(negedge bclk);
    b_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bclk);
  endtask

  task automatic cmp_chan(input string req);
    for (int i = 0; i < NT; i++) begin
      chk(got_cnt[i] == exp_cnt[i], req, $sformatf("strobe count ch%0d", i), DW'(got_cnt[i]), DW'(exp_cnt[i]));
      chk(got_last[i] == exp_last[i], req, $sformatf("data ch%0d", i), got_last[i], exp_last[i]);
    end
  endtask

  initial begin
    repeat (4) @(negedge bclk);
    brst = 1'b0; frst = 1'b0;
    @(negedge bclk);
    // R11 reset state
    chk(pend_stat == '0, "R11", "pend_stat", DW'(pend_stat), 0);
    chk(b_ready && reset_done, "R11", "ready/done", DW'({b_ready, reset_done}), 3);
    chk(posted_o, "R11", "posted default R7", DW'(posted_o), 1);
    chk(f_we == '0 && !dir_we, "R11", "no strobes", DW'(f_we), 0);

    // R3 second write while pending is dropped
    wr(8'h24, 32'hA1A1_0001);
    wr(8'h24, 32'hB2B2_0002);
    idle(50);
    chk(got_cnt[0] == 1, "R3", "ctrl strobe count", DW'(got_cnt[0]), 1);
    chk(got_last[0] == 32'hA1A1_0001, "R3", "ctrl value kept", got_last[0], 32'hA1A1_0001);

    // R4 concurrent channels
    wr(8'h28, 32'h0000_1111);
    wr(8'h38, 32'h0000_4444);
    chk(pend_stat[1] && pend_stat[4], "R4", "two bits pending", DW'(pend_stat), 32'h12);
    wr(8'h58, 32'h9999_0009);
    idle(50);
    cmp_chan("R2");

    // R5 direct and R6 read-only status
    wr(8'h1C, 32'hDEAD_BEEF);
    chk(dir_we && dir_addr == 8'h1C, "R5", "direct write", DW'(dir_addr), 32'h1C);
    wr(8'h34, 32'hFFFF_FFFF);
    chk(!dir_we && pend_stat == '0, "R6", "status write ignored", DW'({dir_we, pend_stat}), 0);

    // R8 non-posted stall
    wr(8'h40, 32'h0);
    chk(!posted_o, "R7", "posted off", DW'(posted_o), 0);
    wr(8'h2C, 32'hC3C3_0003);
    chk(!b_ready && pend_stat == '0, "R8", "stalled, masked", DW'({b_ready, pend_stat}), 0);
    wr(8'h30, 32'h3030_3030);
    idle(60);
    chk(got_cnt[3] == 0, "R8", "write during stall ignored", DW'(got_cnt[3]), 0);
    chk(got_last[2] == 32'hC3C3_0003, "R8", "stalled write delivered", got_last[2], 32'hC3C3_0003);

    // R9/R10 soft reset with a transfer in flight
    wr(8'h40, 32'h4);
    wr(8'h24, 32'hD4D4_0004);
    wr(8'h40, 32'h6);
    chk(!reset_done, "R9", "reset_done falls", DW'(reset_done), 0);
    wr(8'h28, 32'hE5E5_0005);
    idle(100);
    chk(reset_done, "R9", "reset_done back", DW'(reset_done), 1);
    chk(clr_cnt == 1, "R9", "single clear pulse", DW'(clr_cnt), 1);
    chk(got_last[0] == 32'hD4D4_0004, "R10", "in-flight write drained", got_last[0], 32'hD4D4_0004);
    chk(got_last[1] == 32'h0000_1111, "R10", "write during reset dropped", got_last[1], 32'h0000_1111);
    chk(f_wdata[DW-1:0] == '0, "R9", "functional data zeroed", f_wdata[DW-1:0], 0);
    chk(pend_stat == '0 && posted_o, "R9", "pending clear, posted", DW'({posted_o, pend_stat}), 32'h400);

    // R2 operation resumes after soft reset
    wr(8'h50, 32'hF6F6_0006);
    idle(50);
    cmp_chan("R2");

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge bclk);
    if (!fin) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule